// File: doc/BRIEF.md
# Slave-Mode Address Relocation and Bounds Checker

This block sits on the processor's memory address path. Every program address arrives together with a request flag and a mode flag. When the processor runs a user job (slave mode), the block relocates the high-order page field of the address by a per-job base. It also tests that page against the job's allotted upper bound. A request that is out of bounds never reaches memory. Instead it produces a one-cycle fault pulse. When the processor runs supervisor code (master mode), the address goes to memory untouched and no bound is tested.

One 18-bit control word holds both the base and the bound. Bit 0 is the most significant bit. Bits 0–8 (RTL `[17:9]`) hold the base and bits 9–17 (RTL `[8:0]`) hold the bound. The least significant bit of each field is held at zero in hardware, so both the base and the bound move in steps of 1024 words. A dedicated load strobe writes the word.

The address is split into a 9-bit page (bits 0–8, RTL `[17:9]`) and a 9-bit offset (bits 9–17, RTL `[8:0]`). The result of each request is registered, so it appears at the ports one clock after the request.

Top module: `bb_reloc_check`

## Requirements
- R1: After reset, `mem_req`, `mem_fault` and `mem_addr` are zero, and the control word is zero. A slave request for page 0 made before any load therefore faults, because the bound is 0.
- R2: A request with `slave_mode`=0 yields `mem_req`=1, `mem_fault`=0 and `mem_addr` equal to `req_addr` one cycle later, whatever the control word holds.
- R3: A passing slave request yields `mem_addr[17:9]` = `req_addr[17:9]` + base, with `mem_addr[8:0]` = `req_addr[8:0]` unchanged.
- R4: The relocation sum is taken modulo 512, so the carry out of the 9-bit page add is dropped.
- R5: A slave request faults when page >= bound, which is a zero or negative value of bound minus page. It passes when page < bound.
- R6: A faulted request gives `mem_fault`=1 with `mem_req`=0 and `mem_addr`=0 for exactly one cycle. `mem_req` and `mem_fault` are never high together.
- R7: Write-data bits `[9]` and `[0]`, the low bits of the base and bound fields, are ignored by a load and act as zero.
- R8: A load takes effect for requests from the next cycle on. A request made in the same cycle as a load uses the previous control word.
- R9: Each output reflects the request of the previous cycle only. A cycle with `req_valid`=0 yields `mem_req`=0, `mem_fault`=0 and `mem_addr`=0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A memory request is present this cycle |
| req_addr | input | 18 | Program address: `[17:9]` is the page, `[8:0]` is the offset |
| slave_mode | input | 1 | 1 = slave (relocate and check), 0 = master (pass through) |
| bb_load | input | 1 | Writes `bb_wdata` into the base/bound word |
| bb_wdata | input | 18 | New word: `[17:9]` is the base and `[8:0]` is the bound, with bits `[9]` and `[0]` forced to 0 |
| mem_req | output | 1 | Request strobe to memory, one cycle after an accepted request |
| mem_addr | output | 18 | Actual memory address, zero when `mem_req` is low |
| mem_fault | output | 1 | One-cycle memory-fault pulse for a request out of bounds |

## Verification
Every request result (`mem_req`, `mem_addr`, `mem_fault`) is due at the first rising edge after the cycle in which the request was driven. A control-word load changes results only for requests driven in later cycles. The driver applies inputs on the falling edge and queues exactly one expected result per driven cycle. The monitor pops one result and compares it 1 ns after each following rising edge. The bench's own shadow copy of the control word is updated only after the expected value for that cycle has been computed, which captures the one-cycle load delay.

// File: rtl/bb_pkg.sv
`timescale 1ns/1ps
package bb_pkg;
  // Default geometry: 18-bit addresses with a 9-bit page field.
  localparam int unsigned ADDR_W_DEF = 18;
  localparam int unsigned PAGE_W_DEF = 9;

  // Outcome of one request as decided by the translate/check logic.
  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_PASS  = 2'd1,
    XS_FAULT = 2'd2
  } xlate_res_e;
endpackage

// File: rtl/bb_rst_sync.sv
`timescale 1ns/1ps
module bb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bb_word_reg.sv
`timescale 1ns/1ps
module bb_word_reg #(
  parameter int unsigned PAGE_W = bb_pkg::PAGE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2*PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] base,
  output logic [PAGE_W-1:0] bound
);
  localparam int unsigned REG_W  = 2 * PAGE_W;
  localparam int unsigned FIELDS = 2;

  logic [REG_W-1:0] word_q;
  logic [REG_W-1:0] word_d;
  logic [REG_W-1:0] keep_mask;

  // The low bit of every field is wired to zero.
  for (genvar g = 0; g < FIELDS; g++) begin : g_field_mask
    assign keep_mask[g*PAGE_W]                      = 1'b0;
    assign keep_mask[g*PAGE_W+PAGE_W-1:g*PAGE_W+1]  = '1;
  end

  always_comb begin
    word_d = word_q;
    if (load) begin
      word_d = wdata & keep_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load) begin
      word_q <= word_d;
    end
  end

  assign base  = word_q[REG_W-1:PAGE_W];
  assign bound = word_q[PAGE_W-1:0];

  // R8: the word only changes in the cycle after a load strobe.
  assert_hold_without_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> $stable(word_q));
endmodule

// File: rtl/bb_xlate.sv
`timescale 1ns/1ps
module bb_xlate
  import bb_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned PAGE_W = PAGE_W_DEF
) (
  input  logic              valid,
  input  logic              slave,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] base,
  input  logic [PAGE_W-1:0] bound,
  output xlate_res_e        res,
  output logic [ADDR_W-1:0] phys
);
  localparam int unsigned OFF_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] page_sum;
  logic [PAGE_W:0]   room;
  logic              out_of_range;

  assign page     = addr[ADDR_W-1:OFF_W];
  assign page_sum = page + base;                     // carry dropped
  assign room     = {1'b0, bound} - {1'b0, page};    // bound minus page
  assign out_of_range = room[PAGE_W] || (room == '0);

  always_comb begin
    res  = XS_IDLE;
    phys = addr;
    if (valid) begin
      if (!slave) begin
        res = XS_PASS;
      end else if (out_of_range) begin
        res = XS_FAULT;
      end else begin
        res  = XS_PASS;
        phys = {page_sum, addr[OFF_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/bb_reloc_check.sv
`timescale 1ns/1ps
module bb_reloc_check
  import bb_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned PAGE_W = PAGE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                slave_mode,
  input  logic                bb_load,
  input  logic [2*PAGE_W-1:0] bb_wdata,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_fault
);
  localparam int unsigned OFF_W = ADDR_W - PAGE_W;

  logic              rst_s;
  logic [PAGE_W-1:0] base;
  logic [PAGE_W-1:0] bound;
  xlate_res_e        res;
  logic [ADDR_W-1:0] phys;

  logic              req_d,   req_q;
  logic              fault_d, fault_q;
  logic [ADDR_W-1:0] addr_d,  addr_q;

  bb_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  bb_word_reg #(.PAGE_W(PAGE_W)) u_word (
    .clk   (clk),
    .rst_n (rst_s),
    .load  (bb_load),
    .wdata (bb_wdata),
    .base  (base),
    .bound (bound)
  );

  bb_xlate #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_xlate (
    .valid (req_valid),
    .slave (slave_mode),
    .addr  (req_addr),
    .base  (base),
    .bound (bound),
    .res   (res),
    .phys  (phys)
  );

  always_comb begin
    req_d   = 1'b0;
    fault_d = 1'b0;
    addr_d  = '0;
    case (res)
      XS_PASS: begin
        req_d  = 1'b1;
        addr_d = phys;
      end
      XS_FAULT: fault_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      req_q   <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      req_q   <= req_d;
      fault_q <= fault_d;
      addr_q  <= addr_d;
    end
  end

  assign mem_req   = req_q;
  assign mem_fault = fault_q;
  assign mem_addr  = addr_q;

  // R6: a faulted access never strobes memory.
  assert_fault_blocks_req_R6: assert property (@(posedge clk) disable iff (!rst_s)
    !(mem_req && mem_fault));

  // R2: master-mode requests never fault.
  assert_master_no_fault_R2: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(slave_mode) |-> !mem_fault);

  // R3: the offset field reaches memory unchanged.
  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_s)
    mem_req |-> (mem_addr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])));

  // R9: no request, no activity in the following cycle.
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(req_valid) |-> !(mem_req || mem_fault));
endmodule

// File: tb/bb_reloc_check_bench.sv
`timescale 1ns/1ps
module bb_reloc_check_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [17:0] req_addr;
  logic        slave_mode;
  logic        bb_load;
  logic [17:0] bb_wdata;
  logic        mem_req;
  logic [17:0] mem_addr;
  logic        mem_fault;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [8:0] sh_base  = '0;
  logic [8:0] sh_bound = '0;

  logic        q_req[$];
  logic        q_fault[$];
  logic [17:0] q_addr[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bb_reloc_check u_bb_reloc_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .slave_mode(slave_mode), .bb_load(bb_load), .bb_wdata(bb_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_fault(mem_fault)
  );

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue its expected result.
  task automatic step(input logic v, input logic [17:0] a, input logic s,
                      input logic ld, input logic [17:0] wd, input string tag);
    logic        e_req, e_fault;
    logic [17:0] e_addr;
    logic [8:0]  page;
    @(negedge clk);
    req_valid = v; req_addr = a; slave_mode = s; bb_load = ld; bb_wdata = wd;
    e_req = 1'b0; e_fault = 1'b0; e_addr = '0;
    page = a[17:9];
    if (v) begin
      if (!s) begin
        e_req = 1'b1; e_addr = a;
      end else if (page >= sh_bound) begin
        e_fault = 1'b1;
      end else begin
        e_req = 1'b1; e_addr = {page + sh_base, a[8:0]};
      end
    end
    q_req.push_back(e_req); q_fault.push_back(e_fault);
    q_addr.push_back(e_addr); q_tag.push_back(tag);
    if (ld) begin
      sh_base  = wd[17:9] & 9'h1FE;
      sh_bound = wd[8:0]  & 9'h1FE;
    end
  endtask

  // Monitor: compare one queued result after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_tag.size() > 0) begin
        string t;
        t = q_tag.pop_front();
        check(t, {17'b0, mem_req},   {17'b0, q_req.pop_front()},   "mem_req");
        check(t, {17'b0, mem_fault}, {17'b0, q_fault.pop_front()}, "mem_fault");
        check(t, mem_addr,           q_addr.pop_front(),           "mem_addr");
      end
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_addr = '0; slave_mode = 0; bb_load = 0; bb_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {16'b0, mem_req, mem_fault}, 18'h0, "req/fault in reset");
    check("R1", mem_addr, 18'h0, "addr in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    step(1, {9'h000, 9'h055}, 1, 0, '0, "R1");            // bound 0 after reset -> fault
    step(1, 18'h2ABCD, 0, 0, '0, "R2");                   // master pass-through
    step(0, 18'h3FFFF, 1, 0, '0, "R9");                   // idle
    step(1, {9'h000, 9'h001}, 1, 1, {9'h0A4, 9'h020}, "R8"); // uses old word -> fault
    step(1, {9'h005, 9'h123}, 1, 0, '0, "R8");            // new word applies
    step(1, {9'h01F, 9'h1FF}, 1, 0, '0, "R3");            // last page in bounds
    step(1, {9'h020, 9'h000}, 1, 0, '0, "R5");            // page == bound -> fault
    step(0, '0, 1, 0, '0, "R6");                          // fault lasts one cycle
    step(1, {9'h1FF, 9'h0AA}, 1, 0, '0, "R5");            // far above bound
    step(1, {9'h1FF, 9'h0AA}, 0, 0, '0, "R2");            // master ignores bound
    step(1, {9'h000, 9'h010}, 1, 1, {9'h1F0, 9'h1FE}, "R3");
    step(1, {9'h030, 9'h00F}, 1, 0, '0, "R4");            // 0x030+0x1F0 wraps to 0x020
    step(1, {9'h1FD, 9'h001}, 1, 0, '0, "R5");            // just below bound
    step(1, {9'h1FE, 9'h001}, 1, 0, '0, "R5");            // at bound
    step(0, '0, 0, 1, {9'h003, 9'h005}, "R7");            // low bits of fields ignored
    step(1, {9'h004, 9'h000}, 1, 0, '0, "R7");            // bound acts as 4 -> fault
    step(1, {9'h001, 9'h033}, 1, 0, '0, "R7");            // base acts as 2
    step(1, {9'h003, 9'h100}, 1, 0, '0, "R7");            // page 3 < 4 passes
    step(0, '0, 0, 0, '0, "R9");
    @(posedge clk); #2;
    check("R9", {14'b0, q_tag.size()}, 18'h0, "pending results");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule